// File: doc/BRIEF.md
# Four-Source Minterm and Word Transpose Unit

This execution unit takes four 64-bit source operands, S0 through S3, taken from a run of four consecutive registers, and computes one of three results. The first operation is a three-input bitwise logic function. The low byte of S3 acts as an eight-entry truth table. Each result bit is looked up in that table using the matching bits of S0, S1 and S2. The other two operations treat the four sources as a 4x4 matrix of 16-bit words and return half of its transpose as two 64-bit results. Those two results are meant for an even/odd destination register pair.

The operation is chosen by a 2-bit code, and work starts on a one-cycle start strobe. Results are registered and appear one cycle after the strobe, together with a valid pulse and a flag saying whether the second destination is written. Checking that register indices are legal belongs to the decode stage, not to this unit.

Top module: `quad_xform_unit`

## Requirements
- R1: After synchronous active-high reset, `res_valid` and `res_pair` are 0 and both results are zero.
- R2: With `op` = 0 (logic), every result bit i of `res_a` equals `src3[{src0[i],src1[i],src2[i]}]`, where src0 gives the most significant index bit.
- R3: In logic mode, `src3` bits 63..8 have no effect on `res_a`.
- R4: Truth-table byte 0xE2 gives `src0` where `src1` is 1 and `src2` where `src1` is 0.
- R5: Truth-table byte 0x16 sets a result bit exactly when one of the three inputs is 1.
- R6: Words are numbered 0 to 3 from the most significant end, with word k at bits 63-16k down to 48-16k. With `op` = 1 (upper transpose), `res_a` is word 0 of src0, src1, src2, src3, placed from most to least significant. `res_b` is word 1 of the same four sources in the same order.
- R7: With `op` = 2 (lower transpose), `res_a` holds word 2 of each source and `res_b` holds word 3 of each source, in the same placement as R6.
- R8: `res_valid` is high in exactly the cycle after an accepted start. One accepted start gives a one-cycle pulse, and starts on consecutive cycles give a result in each cycle.
- R9: A logic operation leaves `res_b` unchanged and drives `res_pair` low. A transpose updates `res_a` and `res_b` in the same cycle and drives `res_pair` high.
- R10: A start with `op` = 3 is ignored. No valid pulse follows it and both results keep their values.
- R11: While `start` is low, both results hold, whatever the source inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 0 logic, 1 upper transpose, 2 lower transpose, 3 reserved |
| src0 | input | 64 | Source S0 |
| src1 | input | 64 | Source S1 |
| src2 | input | 64 | Source S2 |
| src3 | input | 64 | Source S3; its low byte is the truth table in logic mode |
| res_a | output | 64 | First (even) result |
| res_b | output | 64 | Second (odd) result, transposes only |
| res_valid | output | 1 | Results updated in this cycle |
| res_pair | output | 1 | Second result was written by the last operation |

## Verification
Every one of the 256 truth-table bytes is applied to sources laid out as 0xF0, 0xCC and 0xAA bytes, so that each bit position carries a different index. Under that layout the output must repeat the truth-table byte, which exposes any swapped index bit. The upper bytes of S3 are varied at the same time, which shows that they cannot leak into the result.

Pseudo-random sources are then compared against a sum-of-products model for the logic mode and against shift-and-mask extraction for both transposes. Separate cases cover the mask-select byte, the exactly-one byte and the known transpose example.

Timing checks cover:
- single and back-to-back strobes;
- the reserved code;
- idle cycles with moving inputs.
Together these separate a missing or stuck valid pulse from a second result that is wrongly overwritten.

// File: rtl/quad_xform_pkg.sv
package quad_xform_pkg;

    localparam int DATA_W = 64;
    localparam int LANE_W = 16;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int SRC_N  = 4;
    localparam int SEL_W  = 3;
    localparam int FN_W   = 1 << SEL_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_LOGIC   = 2'b00,
        OP_XPOSE_U = 2'b01,
        OP_XPOSE_L = 2'b10,
        OP_RSVD    = 2'b11
    } xop_e;

    typedef struct packed {
        logic  fire;
        logic  wr_b;
        word_t a;
        word_t b;
    } xres_t;

endpackage

// File: rtl/qx_minterm_core.sv
module qx_minterm_core
    import quad_xform_pkg::*;
(
    input  word_t           in_x,
    input  word_t           in_y,
    input  word_t           in_z,
    input  logic [FN_W-1:0] table_byte,
    output word_t           out_w
);
    // One truth-table lookup per bit position; x is the top index bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [SEL_W-1:0] idx;
        assign idx      = {in_x[i], in_y[i], in_z[i]};
        assign out_w[i] = table_byte[idx];
    end
endmodule

// File: rtl/qx_word_transpose.sv
module qx_word_transpose
    import quad_xform_pkg::*;
#(
    parameter int LANE_BASE = 0
) (
    input  logic [SRC_N-1:0][DATA_W-1:0] srcs,
    output word_t                        col_first,
    output word_t                        col_second
);
    localparam int HI_FIRST  = DATA_W - 1 - LANE_BASE * LANE_W;
    localparam int HI_SECOND = DATA_W - 1 - (LANE_BASE + 1) * LANE_W;

    // Source j supplies lane j of each output, counted from the top.
    for (genvar j = 0; j < SRC_N; j++) begin : g_src
        localparam int DST_HI = DATA_W - 1 - j * LANE_W;
        assign col_first [DST_HI -: LANE_W] = srcs[j][HI_FIRST  -: LANE_W];
        assign col_second[DST_HI -: LANE_W] = srcs[j][HI_SECOND -: LANE_W];
    end

    initial begin
        assert (SRC_N == LANES && LANE_BASE + 1 < LANES)
            else $error("transpose geometry mismatch");
    end
endmodule

// File: rtl/quad_xform_unit.sv
module quad_xform_unit
    import quad_xform_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] src0,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [DATA_W-1:0] src3,
    output logic [DATA_W-1:0] res_a,
    output logic [DATA_W-1:0] res_b,
    output logic              res_valid,
    output logic              res_pair
);
    logic [SRC_N-1:0][DATA_W-1:0] srcs;
    assign srcs[0] = src0;
    assign srcs[1] = src1;
    assign srcs[2] = src2;
    assign srcs[3] = src3;

    word_t logic_w, up_a, up_b, lo_a, lo_b;
    xop_e  op_q;
    xres_t nxt;

    assign op_q = xop_e'(op);

    qx_minterm_core u_logic (
        .in_x       (src0),
        .in_y       (src1),
        .in_z       (src2),
        .table_byte (src3[FN_W-1:0]),
        .out_w      (logic_w)
    );

    qx_word_transpose #(.LANE_BASE(0)) u_xp_upper (
        .srcs       (srcs),
        .col_first  (up_a),
        .col_second (up_b)
    );

    qx_word_transpose #(.LANE_BASE(LANES / 2)) u_xp_lower (
        .srcs       (srcs),
        .col_first  (lo_a),
        .col_second (lo_b)
    );

    always_comb begin
        nxt = '{fire: 1'b0, wr_b: 1'b0, a: '0, b: '0};
        unique case (op_q)
            OP_LOGIC:   nxt = '{fire: start, wr_b: 1'b0, a: logic_w, b: '0};
            OP_XPOSE_U: nxt = '{fire: start, wr_b: 1'b1, a: up_a, b: up_b};
            OP_XPOSE_L: nxt = '{fire: start, wr_b: 1'b1, a: lo_a, b: lo_b};
            default:    nxt = '{fire: 1'b0, wr_b: 1'b0, a: '0, b: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_a     <= '0;
            res_b     <= '0;
            res_valid <= 1'b0;
            res_pair  <= 1'b0;
        end else begin
            res_valid <= nxt.fire;
            if (nxt.fire) begin
                res_a    <= nxt.a;
                res_pair <= nxt.wr_b;
                if (nxt.wr_b) res_b <= nxt.b;
            end
        end
    end

    // R8: an accepted start yields valid in the next cycle.
    p_valid_after_start_r8: assert property (@(posedge clk) disable iff (rst)
        (start && op != 2'b11) |=> res_valid);

    // R8: no valid pulse without a start in the previous cycle.
    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> !res_valid);

    // R9: a logic op keeps the second result and clears the pair flag.
    p_logic_keeps_b_r9: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'b00) |=> ($stable(res_b) && !res_pair));

    // R9: a transpose raises the pair flag.
    p_xpose_pair_r9: assert property (@(posedge clk) disable iff (rst)
        (start && (op == 2'b01 || op == 2'b10)) |=> res_pair);

    // R10: the reserved code changes nothing.
    p_rsvd_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'b11) |=> (!res_valid && $stable(res_a) && $stable(res_b)));

    // R11: idle cycles hold both results.
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(res_a) && $stable(res_b) && $stable(res_pair)));
endmodule

// File: tb/quad_xform_unit_tb.sv
module quad_xform_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [63:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0;
    logic [63:0] res_a, res_b;
    logic        res_valid, res_pair;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

    always #(CLK_PERIOD / 2) clk = ~clk;

    quad_xform_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src0(s0), .src1(s1), .src2(s2), .src3(s3),
        .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .res_pair(res_pair)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed ^ (seed >> 29);
    endfunction

    // Sum of the eight selected product terms.
    function automatic logic [63:0] logic_ref(input logic [63:0] a, b, c, input logic [7:0] f);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            logic [2:0] kk = 3'(k);
            if (f[k]) r = r | ((kk[2] ? a : ~a) & (kk[1] ? b : ~b) & (kk[0] ? c : ~c));
        end
        return r;
    endfunction

    function automatic logic [15:0] wd(input logic [63:0] x, input int k);
        return 16'((x >> (48 - 16 * k)) & 64'hFFFF);
    endfunction

    function automatic logic [63:0] col(input logic [63:0] a, b, c, d, input int k);
        return {wd(a, k), wd(b, k), wd(c, k), wd(d, k)};
    endfunction

    // Apply one strobe; returns after the next negedge with results due.
    task automatic run_op(input logic [1:0] o, input logic [63:0] a, b, c, d);
        @(negedge clk);
        op = o; s0 = a; s1 = b; s2 = c; s3 = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        logic [63:0] a, b, c, d, ha, hb;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_a", res_a, 64'd0);
        chk("R1 res_b", res_b, 64'd0);
        chk("R1 valid/pair", {62'd0, res_valid, res_pair}, 64'd0);
        rst = 1'b0;

        // Transpose first so res_b holds known data (R6 example)
        run_op(2'b01, 64'h1122334455667788, 64'h99AABBCCDDEEFF00,
                      64'h123456789ABCDEF0, 64'h1111111111111111);
        chk("R6 example first", res_a, 64'h112299AA12341111);
        chk("R6 example second", res_b, 64'h3344BBCC56781111);
        chk("R8 valid after start", {63'd0, res_valid}, 64'd1);
        chk("R9 pair after transpose", {63'd0, res_pair}, 64'd1);
        @(negedge clk);
        chk("R8 single pulse", {63'd0, res_valid}, 64'd0);

        // R7 example
        run_op(2'b10, 64'h1122334455667788, 64'h99AABBCCDDEEFF00,
                      64'h123456789ABCDEF0, 64'h1111111111111111);
        chk("R7 example first", res_a, 64'h5566DDEE9ABC1111);
        chk("R7 example second", res_b, 64'h7788FF00DEF01111);

        // R2/R3 sweep of all truth tables; R9 res_b kept
        hb = res_b;
        for (int f = 0; f < 256; f++) begin
            logic [7:0] fb = 8'(f);
            d = {~fb, fb ^ 8'h5A, fb + 8'd77, 8'(f * 3), ~fb ^ 8'h33, 8'(f >> 1), 8'hC3 ^ fb, fb};
            run_op(2'b00, {8{8'hF0}}, {8{8'hCC}}, {8{8'hAA}}, d);
            chk("R2/R3 table sweep", res_a, {8{fb}});
            chk("R9 logic keeps res_b", res_b, hb);
            chk("R9 logic pair low", {62'd0, res_valid, res_pair}, 64'd2);
        end

        // R4 / R5 known cases
        run_op(2'b00, 64'h11110000, 64'h11001100, 64'h10101010, 64'hFFFF_FFFF_FFFF_FFE2);
        chk("R4 mask select", res_a, 64'h11100010);
        run_op(2'b00, 64'h11110000, 64'h11001100, 64'h10101010, 64'h16);
        chk("R5 exactly one", res_a, 64'h00010110);
        run_op(2'b00, 64'h01234567, 64'h11002266, 64'hF0F000FF, 64'h16);
        chk("R5 exactly one b", res_a, 64'hE0D36798);
        for (int t = 0; t < 40; t++) begin
            a = rnd(); b = rnd(); c = rnd();
            run_op(2'b00, a, b, c, {rnd() & ~64'hFF} | 64'hE2);
            chk("R4 random mask select", res_a, (a & b) | (c & ~b));
            run_op(2'b00, a, b, c, 64'h16);
            chk("R5 random exactly one", res_a, (a & ~b & ~c) | (~a & b & ~c) | (~a & ~b & c));
        end

        // R2/R6/R7 random
        for (int t = 0; t < 200; t++) begin
            a = rnd(); b = rnd(); c = rnd(); d = rnd();
            run_op(2'b00, a, b, c, d);
            chk("R2 random logic", res_a, logic_ref(a, b, c, d[7:0]));
            run_op(2'b01, a, b, c, d);
            chk("R6 random first", res_a, col(a, b, c, d, 0));
            chk("R6 random second", res_b, col(a, b, c, d, 1));
            run_op(2'b10, a, b, c, d);
            chk("R7 random first", res_a, col(a, b, c, d, 2));
            chk("R7 random second", res_b, col(a, b, c, d, 3));
        end

        // R8 back-to-back strobes
        a = rnd(); b = rnd(); c = rnd(); d = rnd();
        @(negedge clk);
        op = 2'b01; s0 = a; s1 = b; s2 = c; s3 = d; start = 1'b1;
        @(negedge clk);
        op = 2'b10;
        chk("R8 b2b first valid", {63'd0, res_valid}, 64'd1);
        chk("R8 b2b first data", res_a, col(a, b, c, d, 0));
        @(negedge clk);
        start = 1'b0;
        chk("R8 b2b second valid", {63'd0, res_valid}, 64'd1);
        chk("R8 b2b second data", res_b, col(a, b, c, d, 3));
        @(negedge clk);
        chk("R8 b2b ends", {63'd0, res_valid}, 64'd0);

        // R10 reserved code
        ha = res_a; hb = res_b;
        run_op(2'b11, rnd(), rnd(), rnd(), rnd());
        chk("R10 reserved no valid", {63'd0, res_valid}, 64'd0);
        chk("R10 reserved res_a", res_a, ha);
        chk("R10 reserved res_b", res_b, hb);

        // R11 idle with moving inputs
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            op = 2'(t); s0 = rnd(); s1 = rnd(); s2 = rnd(); s3 = rnd();
        end
        @(negedge clk);
        chk("R11 idle res_a", res_a, ha);
        chk("R11 idle res_b", res_b, hb);
        chk("R11 idle valid", {63'd0, res_valid}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule